// File: doc/BRIEF.md
# Speculative Load Ordering Queue

This block keeps a record of loads that were sent to memory before the addresses of all older stores were known. Each load takes a slot in program order when it is dispatched. The execution stage writes the load's address into that slot and marks the load complete. Every store that commits is checked against the completed loads that are younger than it. If a younger load read the same address too early, its slot is marked with an ordering trap.

Commit logic retires loads from the oldest slot. When the reorder buffer's oldest instruction is a load, commit waits until that slot is complete. A clean load is then retired. A trapped load instead raises a flush request that carries the load's program-counter tag, so fetch can restart at that load. A flush empties the queue and sets both pointers back to slot 0. Forwarding, cache access and the pipeline flush itself belong to other blocks.

Top module: `spec_load_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, the queue is empty, `alloc_ready_o` is 1, `alloc_idx_o` is 0, and `ld_commit_ok_o` and `flush_o` are 0.
- R2: When `alloc_valid_i` and `alloc_ready_o` are both high, a load is placed in slot `alloc_idx_o`, and the next free slot advances by one modulo DEPTH (DEPTH is a power of two, default 32). When DEPTH slots are in use, `alloc_ready_o` is 0 and an allocation request is ignored.
- R3: A pulse on `exec_valid_i` stores `exec_addr_i` in slot `exec_idx_i` and marks that slot complete. A pulse aimed at an unused slot has no effect.
- R4: A pulse on `st_commit_valid_i` sets the trap mark on every occupied, complete slot that meets two conditions. Its address must equal `st_commit_addr_i`. Its age tag must be younger than `st_commit_age_i`, which means that (load age − store age) modulo 2^AGE_W is nonzero and below 2^(AGE_W−1).
- R5: A committing store leaves a slot unmarked in three cases: the load is not younger, the load is not yet complete, or the addresses differ.
- R6: A load that executes in the same cycle as a committing store is compared using its new address. If it matches and is younger, it is trapped.
- R7: When `ld_commit_req_i` is high, the oldest slot is occupied and complete, and that slot is not trapped, `ld_commit_ok_o` is 1 in that cycle and the slot is freed. In all other cases `ld_commit_ok_o` is 0. A load that executes in the same cycle as the commit request does not count as complete yet.
- R8: When `ld_commit_req_i` is high and the oldest slot is complete and trapped, `flush_o` is 1 and `flush_pc_o` carries that load's PC tag. The load is not retired.
- R9: A store hit on the oldest slot in the same cycle as its commit request counts as a trap, and gives a flush rather than a retire.
- R10: In the cycle after a flush, every slot is empty and the next allocation goes to slot 0. Allocation, execution and store requests made in the flush cycle are dropped.
- R11: A commit request while the queue is empty produces neither a retire nor a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Dispatch a load into the queue |
| alloc_age_i | input | AGE_W | Age tag of the dispatched load |
| alloc_pc_i | input | PC_W | PC tag of the dispatched load |
| alloc_ready_o | output | 1 | The queue has a free slot |
| alloc_idx_o | output | PTR_W | Slot that the next allocation takes |
| exec_valid_i | input | 1 | A load has executed |
| exec_idx_i | input | PTR_W | Slot of the load that executed |
| exec_addr_i | input | ADDR_W | Address the load read |
| st_commit_valid_i | input | 1 | A store commits this cycle |
| st_commit_addr_i | input | ADDR_W | Address of the committing store |
| st_commit_age_i | input | AGE_W | Age tag of the committing store |
| ld_commit_req_i | input | 1 | The reorder buffer's oldest instruction is a load |
| ld_commit_ok_o | output | 1 | The oldest load retires this cycle |
| flush_o | output | 1 | The oldest load was trapped: flush the pipeline |
| flush_pc_o | output | PC_W | PC tag to restart fetch from |

## Verification
Three events can fall in the same cycle, and the ordering between them is the main risk. A store commit can coincide with a load's execution, which tests R6. A store commit can also coincide with the commit request for the oldest load that it hits, which tests R9. The bench creates both cases on purpose, with the address matching and the age younger. It expects a trap for the first case and an immediate flush for the second. A behavioural model of the queue, kept as a list of the loads that are in flight, predicts every output on every clock, including the retire or flush decision in the cycle where all three events meet.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef struct packed {
    logic valid;
    logic done;
    logic trap;
  } lq_flags_t;

  typedef enum logic [1:0] {
    CMT_IDLE   = 2'd0,
    CMT_RETIRE = 2'd1,
    CMT_FLUSH  = 2'd2
  } lq_cmt_e;
endpackage

// File: rtl/lq_ptrs.sv
module lq_ptrs #(
  parameter int DEPTH = 32,
  parameter int PTR_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop_i)  head_q <= head_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/lq_entries.sv
module lq_entries
  import lq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  parameter int AGE_W  = 8,
  parameter int PTR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_we_i,
  input  logic [PTR_W-1:0]  alloc_idx_i,
  input  logic [AGE_W-1:0]  alloc_age_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  input  logic              exec_we_i,
  input  logic [PTR_W-1:0]  exec_idx_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [AGE_W-1:0]  st_age_i,
  input  logic              retire_we_i,
  input  logic [PTR_W-1:0]  retire_idx_i,
  output lq_flags_t         flags_o [DEPTH],
  output logic [PC_W-1:0]   pc_o    [DEPTH],
  output logic [DEPTH-1:0]  hit_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    lq_flags_t         flags_q;
    logic [AGE_W-1:0]  age_q;
    logic [PC_W-1:0]   pc_q;
    logic [ADDR_W-1:0] addr_q;
    logic              exec_here, eff_done, younger;
    logic [ADDR_W-1:0] eff_addr;
    logic [AGE_W-1:0]  age_diff;

    assign exec_here = exec_we_i && (exec_idx_i == PTR_W'(g)) && flags_q.valid;
    assign eff_done  = flags_q.done || exec_here;
    assign eff_addr  = exec_here ? exec_addr_i : addr_q;
    // modular age distance: younger when nonzero and in the lower half
    assign age_diff  = age_q - st_age_i;
    assign younger   = (age_diff != '0) && !age_diff[AGE_W-1];
    assign hit_o[g]  = st_valid_i && flags_q.valid && eff_done &&
                       (eff_addr == st_addr_i) && younger;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_q <= '0;
      end else if (flush_i) begin
        flags_q <= '0;
      end else if (alloc_we_i && alloc_idx_i == PTR_W'(g)) begin
        flags_q <= '{valid: 1'b1, done: 1'b0, trap: 1'b0};
      end else begin
        if (retire_we_i && retire_idx_i == PTR_W'(g)) flags_q.valid <= 1'b0;
        if (exec_here) flags_q.done <= 1'b1;
        if (hit_o[g])  flags_q.trap <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (alloc_we_i && alloc_idx_i == PTR_W'(g)) begin
        age_q <= alloc_age_i;
        pc_q  <= alloc_pc_i;
      end
      if (exec_here) addr_q <= exec_addr_i;
    end

    assign flags_o[g] = flags_q;
    assign pc_o[g]    = pc_q;
  end
endmodule

// File: rtl/lq_commit.sv
module lq_commit
  import lq_pkg::*;
(
  input  logic      req_i,
  input  logic      empty_i,
  input  lq_flags_t head_i,
  input  logic      head_hit_i,
  output lq_cmt_e   act_o
);
  always_comb begin
    act_o = CMT_IDLE;
    if (req_i && !empty_i && head_i.valid && head_i.done) begin
      act_o = (head_i.trap || head_hit_i) ? CMT_FLUSH : CMT_RETIRE;
    end
  end
endmodule

// File: rtl/spec_load_queue.sv
module spec_load_queue
  import lq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  parameter int AGE_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [AGE_W-1:0]  alloc_age_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  output logic              alloc_ready_o,
  output logic [PTR_W-1:0]  alloc_idx_o,
  input  logic              exec_valid_i,
  input  logic [PTR_W-1:0]  exec_idx_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic              st_commit_valid_i,
  input  logic [ADDR_W-1:0] st_commit_addr_i,
  input  logic [AGE_W-1:0]  st_commit_age_i,
  input  logic              ld_commit_req_i,
  output logic              ld_commit_ok_o,
  output logic              flush_o,
  output logic [PC_W-1:0]   flush_pc_o
);
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] lq_count;
  logic             full, alloc_fire, retire, flush;
  lq_flags_t        flags [DEPTH];
  logic [PC_W-1:0]  pcs   [DEPTH];
  logic [DEPTH-1:0] hits;
  lq_cmt_e          act;

  assign alloc_fire = alloc_valid_i && !full && !flush;
  assign retire     = (act == CMT_RETIRE);
  assign flush      = (act == CMT_FLUSH);

  lq_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (alloc_fire),
    .pop_i   (retire),
    .flush_i (flush),
    .head_o  (head),
    .tail_o  (tail),
    .count_o (lq_count),
    .full_o  (full)
  );

  lq_entries #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PC_W(PC_W), .AGE_W(AGE_W), .PTR_W(PTR_W)
  ) u_ent (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .alloc_we_i   (alloc_fire),
    .alloc_idx_i  (tail),
    .alloc_age_i  (alloc_age_i),
    .alloc_pc_i   (alloc_pc_i),
    .exec_we_i    (exec_valid_i),
    .exec_idx_i   (exec_idx_i),
    .exec_addr_i  (exec_addr_i),
    .st_valid_i   (st_commit_valid_i),
    .st_addr_i    (st_commit_addr_i),
    .st_age_i     (st_commit_age_i),
    .retire_we_i  (retire),
    .retire_idx_i (head),
    .flags_o      (flags),
    .pc_o         (pcs),
    .hit_o        (hits)
  );

  lq_commit u_cmt (
    .req_i      (ld_commit_req_i),
    .empty_i    (lq_count == '0),
    .head_i     (flags[head]),
    .head_hit_i (hits[head]),
    .act_o      (act)
  );

  assign alloc_ready_o  = !full;
  assign alloc_idx_o    = tail;
  assign ld_commit_ok_o = retire;
  assign flush_o        = flush;
  assign flush_pc_o     = pcs[head];
endmodule

// File: rtl/spec_load_queue_chk.sv
module spec_load_queue_chk #(
  parameter int DEPTH = 32,
  parameter int PTR_W = 5,
  parameter int CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_valid_i,
  input logic             alloc_ready_o,
  input logic [PTR_W-1:0] alloc_idx_o,
  input logic             ld_commit_req_i,
  input logic             ld_commit_ok_o,
  input logic             flush_o,
  input logic [CNT_W-1:0] count_i
);
  p_full_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CNT_W'(DEPTH)) |-> !alloc_ready_o);

  p_alloc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_ready_o && !flush_o) |=>
      (alloc_idx_o == PTR_W'($past(alloc_idx_o) + 1'b1)));

  p_retire_pops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_commit_ok_o && !(alloc_valid_i && alloc_ready_o)) |=>
      (count_i == CNT_W'($past(count_i) - 1'b1)));

  p_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_commit_req_i |-> (!ld_commit_ok_o && !flush_o));

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_commit_ok_o && flush_o));

  p_flush_empties_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (count_i == '0 && alloc_idx_o == '0 && !ld_commit_ok_o && !flush_o));

  p_empty_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0) |-> (!ld_commit_ok_o && !flush_o));
endmodule

bind spec_load_queue spec_load_queue_chk #(
  .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .alloc_valid_i   (alloc_valid_i),
  .alloc_ready_o   (alloc_ready_o),
  .alloc_idx_o     (alloc_idx_o),
  .ld_commit_req_i (ld_commit_req_i),
  .ld_commit_ok_o  (ld_commit_ok_o),
  .flush_o         (flush_o),
  .count_i         (lq_count)
);

// File: tb/tb_spec_load_queue.sv
module tb_spec_load_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 32;
  localparam int ADDR_W = 32;
  localparam int PC_W   = 32;
  localparam int AGE_W  = 8;
  localparam int PTR_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic              alloc_valid_i = 1'b0;
  logic [AGE_W-1:0]  alloc_age_i = '0;
  logic [PC_W-1:0]   alloc_pc_i = '0;
  logic              alloc_ready_o;
  logic [PTR_W-1:0]  alloc_idx_o;
  logic              exec_valid_i = 1'b0;
  logic [PTR_W-1:0]  exec_idx_i = '0;
  logic [ADDR_W-1:0] exec_addr_i = '0;
  logic              st_commit_valid_i = 1'b0;
  logic [ADDR_W-1:0] st_commit_addr_i = '0;
  logic [AGE_W-1:0]  st_commit_age_i = '0;
  logic              ld_commit_req_i = 1'b0;
  logic              ld_commit_ok_o;
  logic              flush_o;
  logic [PC_W-1:0]   flush_pc_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_load_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PC_W(PC_W), .AGE_W(AGE_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_age_i(alloc_age_i), .alloc_pc_i(alloc_pc_i),
    .alloc_ready_o(alloc_ready_o), .alloc_idx_o(alloc_idx_o),
    .exec_valid_i(exec_valid_i), .exec_idx_i(exec_idx_i), .exec_addr_i(exec_addr_i),
    .st_commit_valid_i(st_commit_valid_i), .st_commit_addr_i(st_commit_addr_i),
    .st_commit_age_i(st_commit_age_i),
    .ld_commit_req_i(ld_commit_req_i), .ld_commit_ok_o(ld_commit_ok_o),
    .flush_o(flush_o), .flush_pc_o(flush_pc_o)
  );

  typedef struct {
    int               slot;
    logic [AGE_W-1:0] age;
    logic [PC_W-1:0]  pc;
    logic [ADDR_W-1:0] addr;
    bit               done;
    bit               trap;
  } mload_t;

  mload_t m_q[$];
  int     m_tail = 0;
  int     checks = 0;
  int     failures = 0;
  string  cur_req = "R1";
  bit     done_flag = 1'b0;
  int     last_flush = 0;
  int     last_ok = 0;

  task automatic chk(bit good, string req, string what, longint act, longint exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit younger(logic [AGE_W-1:0] l, logic [AGE_W-1:0] s);
    logic [AGE_W-1:0] d;
    d = l - s;
    return (d != 0) && (int'(d) < (1 << (AGE_W-1)));
  endfunction

  task automatic step();
    mload_t nq[$];
    bit exp_ready, exp_ok, exp_fl, head_hit;
    int exp_idx;
    logic [PC_W-1:0] exp_pc;
    #1;
    nq = m_q;
    head_hit = 1'b0;
    exp_pc = '0;
    foreach (nq[k]) begin
      bit ex, ed, hit;
      logic [ADDR_W-1:0] ea;
      ex = exec_valid_i && (int'(exec_idx_i) == nq[k].slot);
      ed = nq[k].done || ex;
      ea = ex ? exec_addr_i : nq[k].addr;
      hit = st_commit_valid_i && ed && (ea == st_commit_addr_i) &&
            younger(nq[k].age, st_commit_age_i);
      if (ex) begin nq[k].done = 1'b1; nq[k].addr = exec_addr_i; end
      if (hit) nq[k].trap = 1'b1;
      if (k == 0) head_hit = hit;
    end
    exp_ready = (m_q.size() < DEPTH);
    exp_idx = m_tail;
    exp_ok = 1'b0;
    exp_fl = 1'b0;
    if (ld_commit_req_i && m_q.size() > 0 && m_q[0].done) begin
      exp_pc = m_q[0].pc;
      if (m_q[0].trap || head_hit) exp_fl = 1'b1; else exp_ok = 1'b1;
    end
    chk(alloc_ready_o == exp_ready, cur_req, "alloc_ready_o", alloc_ready_o, exp_ready);
    chk(int'(alloc_idx_o) == exp_idx, cur_req, "alloc_idx_o", alloc_idx_o, exp_idx);
    chk(ld_commit_ok_o == exp_ok, cur_req, "ld_commit_ok_o", ld_commit_ok_o, exp_ok);
    chk(flush_o == exp_fl, cur_req, "flush_o", flush_o, exp_fl);
    if (exp_fl) chk(flush_pc_o == exp_pc, cur_req, "flush_pc_o", flush_pc_o, exp_pc);
    last_flush = flush_o;
    last_ok = ld_commit_ok_o;
    if (exp_fl) begin
      nq.delete();
      m_tail = 0;
    end else begin
      if (exp_ok) void'(nq.pop_front());
      if (alloc_valid_i && exp_ready) begin
        mload_t e;
        e.slot = m_tail; e.age = alloc_age_i; e.pc = alloc_pc_i;
        e.addr = '0; e.done = 1'b0; e.trap = 1'b0;
        nq.push_back(e);
        m_tail = (m_tail + 1) % DEPTH;
      end
    end
    @(posedge clk);
    m_q = nq;
    @(negedge clk);
    alloc_valid_i = 1'b0;
    exec_valid_i = 1'b0;
    st_commit_valid_i = 1'b0;
    ld_commit_req_i = 1'b0;
  endtask

  task automatic alloc(int age, int pc);
    alloc_valid_i = 1'b1; alloc_age_i = AGE_W'(age); alloc_pc_i = PC_W'(pc);
  endtask
  task automatic exec(int idx, int addr);
    exec_valid_i = 1'b1; exec_idx_i = PTR_W'(idx); exec_addr_i = ADDR_W'(addr);
  endtask
  task automatic store(int age, int addr);
    st_commit_valid_i = 1'b1; st_commit_age_i = AGE_W'(age); st_commit_addr_i = ADDR_W'(addr);
  endtask

  int age_ctr = 0;

  initial begin
    #(CLK_PERIOD*2 + 1);
    // R1: reset values while held
    chk(alloc_ready_o == 1'b1, "R1", "alloc_ready_o", alloc_ready_o, 1);
    chk(alloc_idx_o == '0, "R1", "alloc_idx_o", alloc_idx_o, 0);
    chk(!ld_commit_ok_o && !flush_o, "R1", "commit outputs", {ld_commit_ok_o, flush_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    step();

    cur_req = "R2";
    alloc(10, 'h100); step();
    alloc(11, 'h104); step();
    alloc(12, 'h108); step();

    cur_req = "R3";
    exec(0, 'hA0); step();
    exec(1, 'hB0); step();
    exec(20, 'hC0); step();           // R3: unused slot, no effect

    cur_req = "R7";
    ld_commit_req_i = 1'b1; step();   // slot 0 retires
    chk(last_ok == 1, "R7", "retire head", last_ok, 1);

    cur_req = "R5";
    store(20, 'hB0); step();          // store younger than load
    store(5, 'hEE); step();           // address differs
    store(5, 'hC8); step();           // slot 2 not yet complete
    ld_commit_req_i = 1'b1; step();   // slot 1 clean
    chk(last_ok == 1 && last_flush == 0, "R5", "untrapped retire", last_ok, 1);

    cur_req = "R7";
    ld_commit_req_i = 1'b1; exec(2, 'hC8); step();  // executing now is not complete
    chk(last_ok == 0, "R7", "wait for completion", last_ok, 0);
    ld_commit_req_i = 1'b1; step();
    chk(last_ok == 1, "R7", "retire after completion", last_ok, 1);

    cur_req = "R4";
    alloc(30, 'h200); step();
    alloc(31, 'h204); step();
    exec(3, 'hD0); step();
    exec(4, 'hD4); step();
    store(29, 'hD4); step();          // traps slot 4 only
    ld_commit_req_i = 1'b1; step();   // slot 3 clean
    chk(last_ok == 1, "R4", "non matching slot retires", last_ok, 1);
    cur_req = "R8";
    ld_commit_req_i = 1'b1; alloc(40, 'h300); step();  // flush, alloc dropped
    chk(last_flush == 1, "R8", "trapped head flushes", last_flush, 1);
    cur_req = "R10";
    step();
    chk(alloc_idx_o == '0, "R10", "alloc_idx_o after flush", alloc_idx_o, 0);

    cur_req = "R6";
    alloc(50, 'h400); step();
    exec(0, 'hE0); store(49, 'hE0); step();
    ld_commit_req_i = 1'b1; step();
    chk(last_flush == 1, "R6", "same-cycle exec trapped", last_flush, 1);

    cur_req = "R9";
    alloc(60, 'h500); step();
    exec(0, 'hF0); step();
    ld_commit_req_i = 1'b1; store(58, 'hF0); step();
    chk(last_flush == 1 && last_ok == 0, "R9", "same-cycle hit flushes", last_flush, 1);

    cur_req = "R11";
    ld_commit_req_i = 1'b1; step();
    chk(last_ok == 0 && last_flush == 0, "R11", "empty commit idle", last_flush, 0);

    cur_req = "R2";
    age_ctr = 70;
    for (int i = 0; i < DEPTH + 2; i++) begin
      alloc(age_ctr, 'h1000 + i); age_ctr++; step();
    end
    chk(alloc_ready_o == 1'b0, "R2", "full blocks", alloc_ready_o, 0);
    cur_req = "R7";
    for (int i = 0; i < DEPTH; i++) begin
      exec(i, 'h40 + i); step();
      ld_commit_req_i = 1'b1; alloc(age_ctr, 'h2000 + i); age_ctr++; step();
    end
    for (int i = 0; i < DEPTH; i++) begin
      exec(i, 'h80); ld_commit_req_i = 1'b1; step();
    end
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule